// File: doc/BRIEF.md
# Quad Serial DAC Write Controller

This block sits between a host register bus and two dual-output serial DACs, which together give four analog channels. Software first writes the low eight bits of a 12-bit code to a value register. It then writes a control register that carries the top four code bits, a two-bit channel selector, a flag that loads only the DAC's input buffer, and a flag that picks a fast or a slow serial clock. That second write starts a 16-bit serial frame to the DAC device that owns the selected channel.

A status register tells software when the next write is accepted. From the control write until the device's chip-select rises after the last bit, the block is busy. Any bus write made while it is busy is dropped. The host interface is a plain register bus: a write strobe, an address and data, with read data decoded from the address without delay. The serial side has a clock, a data line and one active-low chip-select per device.

Top module: `qdac_wr_ctrl`

## Requirements
- R1: After reset, status (offset 6) reads 0x0080, the value register (offset 4) and the control register (offset 5) read 0, both chip-selects are high and the serial clock is low.
- R2: A write to offset 4 stores bits 7:0 and reads back at offset 4. A write to offset 5 stores bits 8:0 and reads back at offset 5. Offsets 0-3 and 7 read 0.
- R3: A write to offset 5 sends a 16-bit frame, MSB first, with data sampled on the rising serial clock. Frame bit 15 is selector bit 7 (output B when 1), bit 14 is the buffer-only flag (control bit 6), bit 13 is the fast flag (control bit 5), bit 12 is 0, and bits 11:0 are the code, made of control bits 3:0 above the value register bits 7:0.
- R4: Control bits 8:7 choose the channel: 00 and 01 use cs_n[0], 10 and 11 use cs_n[1]. At most one chip-select is low at any time.
- R5: Status bit 7 reads 0 from the cycle after the accepted control write until the chip-select rises, and reads 1 again after that.
- R6: While the block is busy, writes to offset 4 and offset 5 are ignored. They change neither register and start no frame.
- R7: The chip-select stays low for 32*FAST_HALF clock cycles when the fast flag is set and for 32*SLOW_HALF cycles when it is clear.
- R8: The serial clock is low whenever both chip-selects are high, and the data line is stable while the serial clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| dac_sclk | output | 1 | Serial clock, idle low |
| dac_sdata | output | 1 | Serial data, MSB first |
| dac_cs_n | output | 2 | Active-low chip-select per device |

## Verification
The bench builds the block with FAST_HALF=1 and SLOW_HALF=3, so each frame lasts 32 or 96 cycles. With these values both speeds, all four channels and both flag values fit in a short run. The slow setting leaves enough time for blocked writes to land in the middle of a frame. The two different half-period values also show whether the fast flag is routed to the divider and not only to the frame bit.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int CODE_W  = 12;
  localparam int FRAME_W = 16;
  localparam int BUS_W   = 16;

  typedef struct packed {
    logic [1:0]        sel;
    logic              buf_only;
    logic              fast;
    logic [CODE_W-1:0] code;
  } dac_req_t;

  function automatic logic [FRAME_W-1:0] build_frame(dac_req_t r);
    return {r.sel[0], r.buf_only, r.fast, 1'b0, r.code};
  endfunction
endpackage

// File: rtl/qdac_regs.sv
module qdac_regs
  import qdac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             busy,
  output logic             start,
  output dac_req_t         req
);
  localparam logic [2:0] A_LOW  = 3'd4;
  localparam logic [2:0] A_CTL  = 3'd5;
  localparam logic [2:0] A_STAT = 3'd6;

  logic [7:0] low_q;
  logic [8:0] ctl_q;
  logic       accept;

  assign accept = bus_wr && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_q <= '0;
      ctl_q <= '0;
    end else if (accept) begin
      if (bus_addr == A_LOW) low_q <= bus_wdata[7:0];
      if (bus_addr == A_CTL) ctl_q <= bus_wdata[8:0];
    end
  end

  assign start        = accept && (bus_addr == A_CTL);
  assign req.sel      = bus_wdata[8:7];
  assign req.buf_only = bus_wdata[6];
  assign req.fast     = bus_wdata[5];
  assign req.code     = {bus_wdata[3:0], low_q};

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_LOW:   bus_rdata[7:0] = low_q;
      A_CTL:   bus_rdata[8:0] = ctl_q;
      A_STAT:  bus_rdata[7]   = !busy;
      default: bus_rdata      = '0;
    endcase
  end
endmodule

// File: rtl/qdac_shifter.sv
module qdac_shifter
  import qdac_pkg::*;
#(
  parameter int FAST_HALF = 2,
  parameter int SLOW_HALF = 8,
  parameter int NUM_CS    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  dac_req_t          req,
  output logic              busy,
  output logic              sclk,
  output logic              sdata,
  output logic [NUM_CS-1:0] cs_n
);
  localparam int MAX_HALF = (FAST_HALF > SLOW_HALF) ? FAST_HALF : SLOW_HALF;
  localparam int DIV_W    = $clog2(MAX_HALF + 1);
  localparam int IDX_W    = $clog2(FRAME_W);
  localparam logic [DIV_W-1:0] FAST_LIM = DIV_W'(FAST_HALF - 1);
  localparam logic [DIV_W-1:0] SLOW_LIM = DIV_W'(SLOW_HALF - 1);

  logic [FRAME_W-1:0] shreg;
  logic [DIV_W-1:0]   div;
  logic [DIV_W-1:0]   lim;
  logic [IDX_W-1:0]   idx;

  assign sdata = shreg[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      sclk  <= 1'b0;
      shreg <= '0;
      div   <= '0;
      lim   <= '0;
      idx   <= '0;
      cs_n  <= '1;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        shreg <= build_frame(req);
        lim   <= req.fast ? FAST_LIM : SLOW_LIM;
        div   <= '0;
        idx   <= '0;
        for (int i = 0; i < NUM_CS; i++)
          cs_n[i] <= !(req.sel[1] == i[0]);
      end
    end else if (div == lim) begin
      div <= '0;
      if (!sclk) begin
        sclk <= 1'b1;
      end else begin
        sclk <= 1'b0;
        if (idx == IDX_W'(FRAME_W - 1)) begin
          busy <= 1'b0;
          cs_n <= '1;
        end else begin
          idx   <= idx + 1'b1;
          shreg <= {shreg[FRAME_W-2:0], 1'b0};
        end
      end
    end else begin
      div <= div + 1'b1;
    end
  end
endmodule

// File: rtl/qdac_wr_ctrl.sv
module qdac_wr_ctrl
  import qdac_pkg::*;
#(
  parameter int FAST_HALF = 2,
  parameter int SLOW_HALF = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        dac_sclk,
  output logic        dac_sdata,
  output logic [1:0]  dac_cs_n
);
  logic     busy;
  logic     start;
  dac_req_t req;

  qdac_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy      (busy),
    .start     (start),
    .req       (req)
  );

  qdac_shifter #(
    .FAST_HALF (FAST_HALF),
    .SLOW_HALF (SLOW_HALF),
    .NUM_CS    (2)
  ) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .req   (req),
    .busy  (busy),
    .sclk  (dac_sclk),
    .sdata (dac_sdata),
    .cs_n  (dac_cs_n)
  );
endmodule

// File: rtl/qdac_wr_ctrl_chk.sv
module qdac_wr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       busy,
  input logic [7:0] low_q,
  input logic [8:0] ctl_q,
  input logic       dac_sclk,
  input logic       dac_sdata,
  input logic [1:0] dac_cs_n
);
  assert_one_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~dac_cs_n));

  assert_sclk_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_cs_n == 2'b11) |-> !dac_sclk);

  assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_sclk && $past(dac_sclk)) |-> $stable(dac_sdata));

  assert_busy_cover_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_cs_n != 2'b11) |-> busy);

  assert_drop_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr) |=> $stable(low_q));

  assert_drop_ctl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr) |=> $stable(ctl_q));
endmodule

bind qdac_wr_ctrl qdac_wr_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .busy      (busy),
  .low_q     (u_regs.low_q),
  .ctl_q     (u_regs.ctl_q),
  .dac_sclk  (dac_sclk),
  .dac_sdata (dac_sdata),
  .dac_cs_n  (dac_cs_n)
);

// File: tb/tb_qdac_wr_ctrl.sv
`timescale 1ns/1ps
module tb_qdac_wr_ctrl;
  localparam int FH = 1;
  localparam int SH = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        dac_sclk, dac_sdata;
  logic [1:0]  dac_cs_n;

  int checks = 0;
  int errors = 0;

  qdac_wr_ctrl #(.FAST_HALF(FH), .SLOW_HALF(SH)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dac_sclk(dac_sclk),
    .dac_sdata(dac_sdata), .dac_cs_n(dac_cs_n));

  always #5 clk = ~clk;

  // serial device model, sampled on falling clk edges
  logic [15:0] cap, got_frame;
  logic [1:0]  prev_cs = 2'b11, got_cs;
  logic        prev_sclk = 1'b0;
  int          low_len = 0, got_len = 0, bits = 0, got_bits = 0, frames = 0;

  always @(negedge clk) begin
    if (dac_cs_n != 2'b11) begin
      if (prev_cs == 2'b11) begin low_len = 0; bits = 0; end
      low_len++;
      if (dac_sclk && !prev_sclk) begin cap = {cap[14:0], dac_sdata}; bits++; end
      got_cs = dac_cs_n;
    end else if (prev_cs != 2'b11) begin
      got_frame = cap; got_len = low_len; got_bits = bits; frames++;
    end
    prev_cs = dac_cs_n;
    prev_sclk = dac_sclk;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [2:0] a, output logic [15:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_frame(int n);
    int t = 0;
    while (frames < n && t < 1000) begin @(negedge clk); t++; end
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    bus_read(3'd6, d); chk("R1 status", d, 16'h0080);
    bus_read(3'd4, d); chk("R1 low", d, 0);
    bus_read(3'd5, d); chk("R1 ctl", d, 0);
    chk("R1 cs", dac_cs_n, 2'b11);
    chk("R1 sclk", dac_sclk, 0);
  endtask

  task automatic t_send(logic [1:0] sel, logic bo, logic fast, logic [11:0] code);
    logic [15:0] d, ctl;
    int n = frames;
    ctl = {7'd0, sel, bo, fast, 1'b0, code[11:8]};
    bus_write(3'd4, {8'd0, code[7:0]});
    bus_read(3'd6, d); chk("R5 ready before start", d[7], 1);
    bus_write(3'd5, ctl);
    bus_read(3'd6, d); chk("R5 busy after write", d[7], 0);
    wait_frame(n + 1);
    chk("R3 frame", got_frame, {sel[0], bo, fast, 1'b0, code});
    chk("R3 bit count", got_bits, 16);
    chk("R4 chip select", got_cs, sel[1] ? 2'b01 : 2'b10);
    chk("R7 frame length", got_len, 32 * (fast ? FH : SH));
    bus_read(3'd6, d); chk("R5 ready after frame", d[7], 1);
    bus_read(3'd4, d); chk("R2 low readback", d, {8'd0, code[7:0]});
    bus_read(3'd5, d); chk("R2 ctl readback", d, ctl);
  endtask

  task automatic t_unused();
    logic [15:0] d;
    for (int a = 0; a < 8; a++) begin
      if (a >= 4 && a <= 6) continue;
      bus_read(a[2:0], d); chk("R2 unused offset", d, 0);
    end
  endtask

  task automatic t_ignore();
    logic [15:0] d;
    int n;
    t_send(2'b10, 1'b0, 1'b0, 12'h5C3);
    n = frames;
    bus_write(3'd5, 16'h0025);
    n = frames;
    bus_write(3'd4, 16'h00AA);
    bus_write(3'd5, 16'h01F7);
    bus_read(3'd4, d); chk("R6 low kept while busy", d, 16'h0000 | 16'h00C3);
    bus_read(3'd5, d); chk("R6 ctl kept while busy", d, 16'h0025);
    wait_frame(n + 1);
    repeat (120) @(negedge clk);
    chk("R6 no extra frame", frames, n + 1);
    chk("R6 frame of first write", got_frame, {1'b0, 1'b0, 1'b1, 1'b0, 12'h5C3});
    chk("R8 idle sclk", dac_sclk, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unused();
    t_send(2'b00, 1'b0, 1'b1, 12'hA5F);
    t_send(2'b01, 1'b1, 1'b0, 12'h3C0);
    t_send(2'b10, 1'b1, 1'b1, 12'hFFF);
    t_send(2'b11, 1'b0, 1'b0, 12'h001);
    t_ignore();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule